// File: doc/BRIEF.md
# Listen-Before-Transmit Access Scheduler

This block decides the clock cycle in which a packet that is waiting to be sent may go on air. A requester raises `tx_valid` together with a configuration: a 2-bit access mode, a slot index, a back-off exponent, the preamble length, the packet length, the turnaround delay and the receiver settle time. The scheduler runs the selected access policy and pulses `tx_ready` for one cycle when the transmitter may be keyed. The four policies are these. The first keys the radio straight away. The second waits a fixed delay that depends on the slot index, which gives time-slotted polling. The third listens until the channel is clear. The fourth listens and, while the channel is busy, waits a pseudo-random number of milliseconds before it listens again.

`tx_valid`/`tx_ready` form a valid/ready pair. The source raises `tx_valid` and holds it, with the configuration, until `tx_ready` is seen. The block captures the configuration in the cycle in which it first sees `tx_valid` while idle, and then ignores `tx_valid` and the configuration pins until it issues the grant. Back-pressure is the whole purpose: `tx_ready` stays low until the access policy is satisfied. The source drops `tx_valid` on the grant cycle. All time is counted in fine ticks of 12.5 µs, which a prescaler derives from `clk` (`FINE_DIV` clocks each), and in millisecond ticks of `MS_TICKS` fine ticks. The prescaler restarts at each phase, so every phase lasts an exact number of clocks. `rx_en` powers the receiver while the channel is sensed. The external detector reports activity on `chan_busy`.

Top module: `chan_access_sched`

## Requirements
- R1: After reset, `tx_ready` and `rx_en` are low and the block is idle.
- R2: Mode 0 (`acc_mode`=2'b00): if `tx_valid` is first seen idle in cycle c, `tx_ready` is high in cycle c+1+T·FINE_DIV, where T = `turn_ticks`, and in no other cycle. T=0 grants in cycle c+1.
- R3: Mode 1 (2'b01): the grant comes in cycle c+1+(S+T)·FINE_DIV, with S = `slot_idx`·(`pre_cycles` + (`pkt_bytes`+2)·BYTE_TICKS + 3·`turn_ticks` + GUARD_TICKS). Slot 0 adds no delay.
- R4: In modes 0 and 1, `rx_en` stays low and `chan_busy` has no effect on the grant cycle.
- R5: Modes 2 and 3 (`acc_mode[1]`=1): `rx_en` rises in cycle c+1. It stays high for `settle_units`·SETTLE_TICKS·FINE_DIV settle cycles and then for the sensing cycles, and it is low during the turnaround.
- R6: While sensing, a cycle with `chan_busy` low starts the turnaround: the grant follows T·FINE_DIV+1 cycles later. In mode 2 a busy cycle just keeps the block sensing.
- R7: In mode 3 a busy sensing cycle turns `rx_en` off for r·MS_TICKS·FINE_DIV cycles, where r = (low 7 bits of the LFSR in that cycle) AND (2^`bo_exp`−1). After that the settle time and sensing run again. If r is 0, the settle time starts at once.
- R8: The LFSR is 16 bits wide and holds 0xACE1 in reset. At every clock edge after reset it shifts left, and the new bit 0 is bit15^bit13^bit12^bit10.
- R9: `abort` high in any cycle makes the next cycle idle, with `tx_ready` and `rx_en` low and all timers cleared. A request that is still valid is then served again from the start.
- R10: Each accepted request produces exactly one single-cycle `tx_ready`. Changes to the configuration pins after acceptance have no effect on that request.
- R11: With `bo_exp` = 0 the back-off is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| abort | input | 1 | Cancel the current schedule and return to idle |
| tx_valid | input | 1 | A packet is waiting for air time |
| tx_ready | output | 1 | One-cycle grant: key the transmitter |
| acc_mode | input | 2 | Bit 1 enables listening, bit 0 enables deferral (slot or back-off) |
| slot_idx | input | 8 | Slot index for mode 1 |
| bo_exp | input | 3 | Back-off exponent n, range 0..7 |
| pre_cycles | input | 8 | Preamble length in fine ticks |
| turn_ticks | input | 8 | Turnaround delay in fine ticks |
| settle_units | input | 8 | Receiver settle time in units of SETTLE_TICKS fine ticks |
| pkt_bytes | input | 6 | Packet length in bytes |
| chan_busy | input | 1 | Channel activity from the detector |
| rx_en | output | 1 | Receiver enable for channel sensing |

## Verification
The hardest situation to reach from the ports is a random back-off of known length. Its length depends on the LFSR value in the one cycle where sensing first meets a busy channel. The bench therefore keeps a cycle-accurate model of the LFSR from reset onward. It holds `chan_busy` high for long, scripted windows in mode 3 with exponents 0, 2 and 3, so that several back-off draws and re-settles happen in a row, and one abort lands inside a back-off. The reference model is compared with `tx_ready` and `rx_en` on every clock.

// File: rtl/cas_pkg.sv
package cas_pkg;
  localparam int CAS_BYTE_W = 8;
  localparam int CAS_EXP_W  = 3;
  localparam int CAS_LEN_W  = 6;
  localparam int CAS_RND_W  = (1 << CAS_EXP_W) - 1;

  typedef enum logic [2:0] {
    S_IDLE, S_SLOT, S_SETTLE, S_SENSE, S_BACKOFF, S_TURN, S_GO
  } cas_state_e;

  typedef struct packed {
    logic                  listen;
    logic                  defer;
    logic [CAS_BYTE_W-1:0] slot;
    logic [CAS_EXP_W-1:0]  exp;
    logic [CAS_BYTE_W-1:0] pre;
    logic [CAS_BYTE_W-1:0] turn;
    logic [CAS_BYTE_W-1:0] settle;
    logic [CAS_LEN_W-1:0]  len;
  } cas_cfg_t;
endpackage

// File: rtl/cas_tick_gen.sv
module cas_tick_gen #(
  parameter int FINE_DIV = 1000,
  parameter int MS_TICKS = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic fine_tick,
  output logic ms_tick
);
  localparam int FW = $clog2(FINE_DIV + 1);
  localparam int MW = $clog2(MS_TICKS + 1);

  logic [FW-1:0] fine_q;
  logic [MW-1:0] ms_q;

  assign fine_tick = (fine_q == FW'(FINE_DIV - 1));
  assign ms_tick   = fine_tick && (ms_q == MW'(MS_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fine_q <= '0;
      ms_q   <= '0;
    end else if (restart) begin
      fine_q <= '0;
      ms_q   <= '0;
    end else begin
      fine_q <= fine_tick ? '0 : fine_q + 1'b1;
      if (fine_tick) ms_q <= ms_tick ? '0 : ms_q + 1'b1;
    end
  end

  generate
    if (FINE_DIV > 1) begin : g_chk
      // R2
      restart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !fine_tick);
    end
  endgenerate
endmodule

// File: rtl/cas_lfsr.sv
module cas_lfsr #(
  parameter int          W     = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter int          OUT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= SEED;
    else        sr_q <= {sr_q[W-2:0], ^(sr_q & TAPS)};
  end

  assign rnd_o = sr_q[OUT_W-1:0];

  // R8
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q != '0);
endmodule

// File: rtl/cas_slot_calc.sv
module cas_slot_calc #(
  parameter int BYTE_W      = 8,
  parameter int LEN_W       = 6,
  parameter int BYTE_TICKS  = 6,
  parameter int GUARD_TICKS = 40,
  parameter int CNT_W       = 19
) (
  input  logic [BYTE_W-1:0] slot,
  input  logic [BYTE_W-1:0] pre,
  input  logic [BYTE_W-1:0] turn,
  input  logic [LEN_W-1:0]  len,
  output logic [CNT_W-1:0]  slot_ticks
);
  logic [CNT_W-1:0] frame_ticks;
  logic [CNT_W-1:0] unit_ticks;

  always_comb begin
    frame_ticks = (CNT_W'(len) + CNT_W'(2)) * CNT_W'(BYTE_TICKS);
    unit_ticks  = CNT_W'(pre) + frame_ticks + CNT_W'(3) * CNT_W'(turn)
                + CNT_W'(GUARD_TICKS);
    slot_ticks  = CNT_W'(slot) * unit_ticks;
  end
endmodule

// File: rtl/chan_access_sched.sv
module chan_access_sched
  import cas_pkg::*;
#(
  parameter int          FINE_DIV     = 1000,
  parameter int          MS_TICKS     = 80,
  parameter int          SETTLE_TICKS = 8,
  parameter int          BYTE_TICKS   = 6,
  parameter int          GUARD_TICKS  = 40,
  parameter logic [15:0] LFSR_SEED    = 16'hACE1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  abort,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  input  logic [1:0]            acc_mode,
  input  logic [CAS_BYTE_W-1:0] slot_idx,
  input  logic [CAS_EXP_W-1:0]  bo_exp,
  input  logic [CAS_BYTE_W-1:0] pre_cycles,
  input  logic [CAS_BYTE_W-1:0] turn_ticks,
  input  logic [CAS_BYTE_W-1:0] settle_units,
  input  logic [CAS_LEN_W-1:0]  pkt_bytes,
  input  logic                  chan_busy,
  output logic                  rx_en
);
  localparam int BMAX     = (1 << CAS_BYTE_W) - 1;
  localparam int LMAX     = (1 << CAS_LEN_W) - 1;
  localparam int UNIT_MAX = BMAX + (LMAX + 2) * BYTE_TICKS + 3 * BMAX + GUARD_TICKS;
  localparam int SLOT_MAX = BMAX * UNIT_MAX;
  localparam int SET_MAX  = BMAX * SETTLE_TICKS;
  localparam int CNT_MAX  = (SLOT_MAX > SET_MAX) ? SLOT_MAX : SET_MAX;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  cas_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  cas_cfg_t         cfg_in, cfg_q, cfg_s;
  logic [CNT_W-1:0] slot_ticks;
  logic [CAS_RND_W-1:0] rnd, bo_mask, bo_draw;
  logic             fine_tick, ms_tick, tick_sel, timed, expire, restart;
  cas_state_e       turn_st, listen_st;
  logic [CNT_W-1:0] turn_cnt, listen_cnt;

  always_comb begin
    cfg_in.listen = acc_mode[1];
    cfg_in.defer  = acc_mode[0];
    cfg_in.slot   = slot_idx;
    cfg_in.exp    = bo_exp;
    cfg_in.pre    = pre_cycles;
    cfg_in.turn   = turn_ticks;
    cfg_in.settle = settle_units;
    cfg_in.len    = pkt_bytes;
  end

  assign cfg_s = (state_q == S_IDLE) ? cfg_in : cfg_q;

  cas_slot_calc #(
    .BYTE_W(CAS_BYTE_W), .LEN_W(CAS_LEN_W), .BYTE_TICKS(BYTE_TICKS),
    .GUARD_TICKS(GUARD_TICKS), .CNT_W(CNT_W)
  ) u_slot (
    .slot(cfg_s.slot), .pre(cfg_s.pre), .turn(cfg_s.turn), .len(cfg_s.len),
    .slot_ticks(slot_ticks)
  );

  cas_lfsr #(.W(16), .SEED(LFSR_SEED), .TAPS(16'hB400), .OUT_W(CAS_RND_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .rnd_o(rnd)
  );

  cas_tick_gen #(.FINE_DIV(FINE_DIV), .MS_TICKS(MS_TICKS)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .fine_tick(fine_tick), .ms_tick(ms_tick)
  );

  assign bo_mask = CAS_RND_W'(({{CAS_RND_W{1'b0}}, 1'b1} << cfg_s.exp) - 1'b1);
  assign bo_draw = rnd & bo_mask;

  // Entry points of the phases that are skipped when their duration is zero
  always_comb begin
    if (cfg_s.turn != '0) begin
      turn_st  = S_TURN;
      turn_cnt = CNT_W'(cfg_s.turn);
    end else begin
      turn_st  = S_GO;
      turn_cnt = '0;
    end
    if (cfg_s.settle != '0) begin
      listen_st  = S_SETTLE;
      listen_cnt = CNT_W'(cfg_s.settle) * CNT_W'(SETTLE_TICKS);
    end else begin
      listen_st  = S_SENSE;
      listen_cnt = '0;
    end
  end

  assign timed    = (state_q == S_SLOT) || (state_q == S_SETTLE) ||
                    (state_q == S_BACKOFF) || (state_q == S_TURN);
  assign tick_sel = (state_q == S_BACKOFF) ? ms_tick : fine_tick;
  assign expire   = timed && tick_sel && (cnt_q == CNT_W'(1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (timed && tick_sel && !expire) cnt_d = cnt_q - 1'b1;
    unique case (state_q)
      S_IDLE: if (tx_valid) begin
        if (cfg_s.listen) begin
          state_d = listen_st;  cnt_d = listen_cnt;
        end else if (cfg_s.defer && slot_ticks != '0) begin
          state_d = S_SLOT;     cnt_d = slot_ticks;
        end else begin
          state_d = turn_st;    cnt_d = turn_cnt;
        end
      end
      S_SLOT:   if (expire) begin state_d = turn_st;  cnt_d = turn_cnt; end
      S_SETTLE: if (expire) begin state_d = S_SENSE;  cnt_d = '0;       end
      S_SENSE: begin
        if (!chan_busy) begin
          state_d = turn_st; cnt_d = turn_cnt;
        end else if (cfg_s.defer) begin
          if (bo_draw != '0) begin
            state_d = S_BACKOFF; cnt_d = CNT_W'(bo_draw);
          end else begin
            state_d = listen_st; cnt_d = listen_cnt;
          end
        end
      end
      S_BACKOFF: if (expire) begin state_d = listen_st; cnt_d = listen_cnt; end
      S_TURN:    if (expire) begin state_d = S_GO;      cnt_d = '0;         end
      S_GO:      begin state_d = S_IDLE; cnt_d = '0; end
      default:   begin state_d = S_IDLE; cnt_d = '0; end
    endcase
    if (abort) begin
      state_d = S_IDLE;
      cnt_d   = '0;
    end
  end

  assign restart = (state_d != state_q) || (state_q == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (state_q == S_IDLE) cfg_q <= cfg_in;
    end
  end

  assign tx_ready = (state_q == S_GO);
  assign rx_en    = (state_q == S_SETTLE) || (state_q == S_SENSE);

  // R10
  grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!tx_ready && !rx_en));

  // R7
  backoff_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_BACKOFF) |-> (cnt_q != '0 && cnt_q <= CNT_W'(bo_mask)));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_SENSE && chan_busy) |=> (!tx_ready && state_q != S_TURN));
endmodule

// File: tb/chan_access_sched_test.sv
module chan_access_sched_test;
  localparam int FD = 3;
  localparam int MS = 80;
  localparam int ST = 8;
  localparam int BT = 6;
  localparam int GT = 40;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0, rst_n = 1'b0, abort = 1'b0, tx_valid = 1'b0, chan_busy = 1'b0;
  logic [1:0] acc_mode = 2'b00;
  logic [7:0] slot_idx = '0, pre_cycles = '0, turn_ticks = '0, settle_units = '0;
  logic [2:0] bo_exp = '0;
  logic [5:0] pkt_bytes = '0;
  logic tx_ready, rx_en;

  always #4 clk = ~clk;

  chan_access_sched #(.FINE_DIV(FD), .MS_TICKS(MS), .SETTLE_TICKS(ST),
                      .BYTE_TICKS(BT), .GUARD_TICKS(GT)) uut (
    .clk(clk), .rst_n(rst_n), .abort(abort), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .acc_mode(acc_mode), .slot_idx(slot_idx), .bo_exp(bo_exp), .pre_cycles(pre_cycles),
    .turn_ticks(turn_ticks), .settle_units(settle_units), .pkt_bytes(pkt_bytes),
    .chan_busy(chan_busy), .rx_en(rx_en)
  );

  int vectors = 0, miscompares = 0, cyc = 0, busy_until = 0;
  string tag = "R1";
  bit done = 0;

  // Reference model: 0 idle, 1 wait then grant, 2 settle, 3 sense, 4 back-off, 5 grant
  int m_st = 0, m_rem = 0, m_lf = 16'hACE1;
  int c_listen, c_defer, c_slot, c_exp, c_pre, c_turn, c_settle, c_len;

  task automatic m_to_listen();
    m_rem = c_settle * ST * FD;
    m_st  = (m_rem > 0) ? 2 : 3;
  endtask

  task automatic m_to_wait(input int ticks);
    m_rem = ticks * FD;
    m_st  = (m_rem > 0) ? 1 : 5;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_rem = 0; m_lf = 16'hACE1;
    end else begin
      if (abort) begin
        m_st = 0; m_rem = 0;
      end else begin
        case (m_st)
          0: if (tx_valid) begin
            c_listen = int'(acc_mode[1]); c_defer = int'(acc_mode[0]);
            c_slot = int'(slot_idx); c_exp = int'(bo_exp); c_pre = int'(pre_cycles);
            c_turn = int'(turn_ticks); c_settle = int'(settle_units); c_len = int'(pkt_bytes);
            if (c_listen != 0) m_to_listen();
            else if (c_defer != 0)
              m_to_wait(c_slot * (c_pre + (c_len + 2) * BT + 3 * c_turn + GT) + c_turn);
            else m_to_wait(c_turn);
          end
          1: begin m_rem--; if (m_rem == 0) m_st = 5; end
          2: begin m_rem--; if (m_rem == 0) m_st = 3; end
          3: begin
            if (!chan_busy) m_to_wait(c_turn);
            else if (c_defer != 0) begin
              int r;
              r = m_lf & ((1 << c_exp) - 1);
              if (r > 0) begin m_rem = r * MS * FD; m_st = 4; end
              else m_to_listen();
            end
          end
          4: begin m_rem--; if (m_rem == 0) m_to_listen(); end
          default: m_st = 0;
        endcase
      end
      m_lf = ((m_lf << 1) | (((m_lf >> 15) ^ (m_lf >> 13) ^ (m_lf >> 12) ^ (m_lf >> 10)) & 1)) & 16'hFFFF;
    end
  end

  // channel activity generator, single writer of chan_busy
  always begin
    @(posedge clk);
    #2;
    chan_busy = (cyc < busy_until);
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    logic e_ready, e_rx;
    e_ready = (m_st == 5);
    e_rx    = (m_st == 2) || (m_st == 3);
    vectors++;
    if (tx_ready !== e_ready || rx_en !== e_rx) begin
      miscompares++;
      $display("FAIL %s cycle %0d: tx_ready=%b rx_en=%b, expected tx_ready=%b rx_en=%b",
               tag, cyc, tx_ready, rx_en, e_ready, e_rx);
    end
    if (cyc > WATCHDOG) begin
      miscompares++;
      $display("FAIL watchdog: run hung at cycle %0d, actual no finish, expected finish", cyc);
      finish_run();
    end
  end

  task automatic set_cfg(input logic [1:0] m, input int slot, input int ex, input int pre,
                         input int turn, input int settle, input int len);
    acc_mode = m; slot_idx = 8'(slot); bo_exp = 3'(ex); pre_cycles = 8'(pre);
    turn_ticks = 8'(turn); settle_units = 8'(settle); pkt_bytes = 6'(len);
  endtask

  task automatic wait_grant();
    for (int k = 0; k < 60000; k++) begin
      @(negedge clk);
      if (tx_ready) break;
    end
    tx_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_req(input string t, input logic [1:0] m, input int slot, input int ex,
                         input int pre, input int turn, input int settle, input int len,
                         input int busy_len);
    @(negedge clk);
    tag = t;
    set_cfg(m, slot, ex, pre, turn, settle, len);
    busy_until = cyc + busy_len;
    tx_valid = 1'b1;
    wait_grant();
  endtask

  initial begin
    tag = "R1";
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run_req("R2", 2'b00, 0, 0, 0, 5, 0, 0, 0);
    run_req("R2", 2'b00, 0, 0, 0, 0, 0, 0, 0);
    run_req("R4", 2'b00, 9, 3, 7, 2, 4, 8, 500);
    run_req("R3", 2'b01, 2, 0, 10, 2, 0, 4, 0);
    run_req("R3", 2'b01, 0, 0, 10, 3, 0, 4, 0);
    run_req("R4", 2'b01, 1, 5, 20, 1, 3, 60, 2000);

    // R10: pins change right after acceptance
    @(negedge clk);
    tag = "R10";
    set_cfg(2'b01, 1, 0, 5, 4, 0, 2);
    tx_valid = 1'b1;
    @(negedge clk);
    set_cfg(2'b10, 7, 7, 200, 90, 9, 50);
    wait_grant();

    run_req("R5", 2'b10, 0, 0, 0, 2, 3, 0, 0);
    run_req("R6", 2'b10, 0, 0, 0, 3, 2, 0, 150);
    run_req("R6", 2'b10, 0, 0, 0, 0, 0, 0, 40);
    run_req("R7", 2'b11, 0, 2, 0, 1, 1, 0, 400);
    run_req("R8", 2'b11, 0, 3, 0, 2, 2, 0, 1500);
    run_req("R11", 2'b11, 0, 0, 0, 1, 1, 0, 90);

    // R9: abort during a slot delay, request kept valid and served again
    @(negedge clk);
    tag = "R9";
    set_cfg(2'b01, 1, 0, 4, 1, 0, 1);
    tx_valid = 1'b1;
    repeat (40) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    wait_grant();

    // R9: abort while backing off
    @(negedge clk);
    set_cfg(2'b11, 0, 2, 0, 1, 1, 0);
    busy_until = cyc + 3000;
    tx_valid = 1'b1;
    repeat (60) @(negedge clk);
    abort = 1'b1;
    tx_valid = 1'b0;
    @(negedge clk);
    abort = 1'b0;
    repeat (20) @(negedge clk);
    busy_until = cyc;
    tx_valid = 1'b1;
    wait_grant();

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule